// File: doc/BRIEF.md
# Cassette Controller Host Register Interface

This block sits between a processor's I/O instruction path and the data transfer engine of a controller for two cassette drives. Each instruction strobe carries a 3-bit sub-operation and the 12-bit accumulator. The block decodes the sub-operation into one of these actions: a full clear, four skip tests, a load of the command register, a go request, or a read of the status word. It returns an accumulator result and a skip decision one cycle later.

The command register holds an enable bit, a drive select bit, a 3-bit tape function and an interrupt enable. The status word combines two kinds of bits. Some are error bits latched from the engine's event inputs. The rest are computed every cycle from the attached, write-protect and busy lines of one drive. The block derives the interrupt request from the status word and the data flag. A go request is acted on in one of two ways. If no drive is moving, it is a start: it is checked here, may raise a write-lock error, and otherwise reaches the engine as a start pulse. If a drive is moving, the engine gets a continue pulse.

Top module: `cas_host_regs`

## Requirements
- R1: After reset the command register and all latched status are zero, so the interrupt request, `res_valid`, `go_start` and `go_cont` are low, and a status read returns zero.
- R2: Sub-op 4 loads the command register from accumulator bits: bit 7 enable, bit 6 drive select, bits 5:3 function, bit 0 interrupt enable. It returns the low 8 accumulator bits inverted, with the upper 4 bits zero and no skip.
- R3: Sub-op 7 returns the status word in bits 7:0, with upper bits zero. The bits are: 7 CRC error, 6 timing error, 5 tape end mark, 4 end of file, 3 drive empty, 2 rewinding, 1 write locked, 0 ready. The whole word reads as zero while enable is clear.
- R4: The live bits come from the lowest-numbered busy drive, or from the selected drive if none is busy. A detached drive shows empty and write locked, and never shows rewinding. An idle drive shows ready. Write locked is also shown for a protected drive and while rewinding.
- R5: The sub-ops test for a skip as follows. Sub-op 1 skips on the data flag. Sub-op 2 skips on any error (the write-lock error, CRC, timing, end mark, end of file, or empty). Sub-op 3 skips when the drive is ready and not empty. Sub-op 5 skips on the data flag, any error, or ready. Sub-ops 0, 4, 6 and 7 never skip.
- R6: The interrupt request is high exactly when interrupt enable is set and either the data flag, any visible error, or visible ready is set.
- R7: A go with no drive busy acts only if enable is set and the selected drive is attached. It then clears the write-lock, CRC, timing, end-mark and end-of-file errors and the rewinding latch. A write function (2 or 4) on a protected drive sets the write-lock error and produces no start. Otherwise `go_start` pulses with the function, drive and accumulator bits 7:0, and function 1 (rewind) sets the rewinding latch.
- R8: A go while any drive is busy pulses `go_cont` and changes no error bit. Every go clears the data flag.
- R9: An engine data-flag pulse sets the data flag. If the flag is already set and no go arrives in the same cycle, the pulse also sets the timing error. The CRC, end-of-file and end-mark inputs latch their error bits.
- R10: Sub-op 0 clears the command register, all latched errors and the data flag. It wins over error events in the same cycle.
- R11: `res_valid` is high for exactly the cycle after each strobe. For sub-ops 0, 1, 2, 3, 5 and 6, `res_acc` equals the strobed accumulator.
- R12: The write-lock error is not part of the 8-bit status read, but it counts for the sub-op 2 and 5 skips and for the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_stb | input | 1 | Instruction strobe, one cycle per instruction |
| iot_op | input | 3 | Sub-operation code |
| acc_in | input | 12 | Accumulator value with the strobe |
| drv_attached | input | NDRV | Drive has a cassette loaded |
| drv_wprot | input | NDRV | Drive is write protected |
| drv_busy | input | NDRV | Drive is executing an operation |
| eng_df_set | input | 1 | Engine pulse: character ready / taken |
| eng_crc_err | input | 1 | Engine pulse: CRC error |
| eng_eof | input | 1 | Engine pulse: file gap reached |
| eng_end_mark | input | 1 | Engine pulse: tape start or end reached |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_acc | output | 12 | Accumulator result |
| res_skip | output | 1 | Skip decision |
| irq | output | 1 | Interrupt request |
| go_start | output | 1 | Start pulse to the engine |
| go_cont | output | 1 | Continue pulse to the engine |
| go_fn | output | 3 | Function sent with a go pulse |
| go_unit | output | 1 | Drive sent with a go pulse |
| go_wdata | output | 8 | Accumulator bits 7:0 sent with a go pulse |

## Verification
The properties assume that the strobe lasts one cycle per instruction and that sub-op codes are taken as given. They also assume that engine event pulses are single-cycle and may arrive at any time, including in the same cycle as a clear. The bench changes drive attach, protect and busy lines only between instructions and at the falling edge. It raises busy only after a start pulse, as an engine would. This keeps every status read tied to a known drive state.

// File: rtl/cas_pkg.sv
package cas_pkg;

    localparam int ACC_W    = 12;
    localparam int BYTE_W   = 8;
    localparam int STAT_W   = 9;

    typedef enum logic [2:0] {
        IOP_CLEAR    = 3'd0,
        IOP_SKIP_DF  = 3'd1,
        IOP_SKIP_ERR = 3'd2,
        IOP_SKIP_RDY = 3'd3,
        IOP_LOAD_A   = 3'd4,
        IOP_SKIP_ANY = 3'd5,
        IOP_GO       = 3'd6,
        IOP_READ_B   = 3'd7
    } iot_op_e;

    typedef enum logic [2:0] {
        FN_READ      = 3'd0,
        FN_REWIND    = 3'd1,
        FN_WRITE     = 3'd2,
        FN_SPC_RFILE = 3'd3,
        FN_GAP       = 3'd4,
        FN_SPC_RBLK  = 3'd5,
        FN_CRC       = 3'd6,
        FN_SPC_FFILE = 3'd7
    } tape_fn_e;

    // command register, only the bits that carry meaning are stored
    typedef struct packed {
        logic     enable;
        logic     unit;
        tape_fn_e fn;
        logic     irq_en;
    } cmd_reg_t;

    // status word, bit 8 down to bit 0
    typedef struct packed {
        logic wr_lock_err;
        logic crc_err;
        logic timing_err;
        logic end_mark;
        logic end_file;
        logic empty;
        logic rewinding;
        logic wr_locked;
        logic ready;
    } stat_word_t;

    typedef struct packed {
        logic wle;
        logic crc;
        logic tim;
        logic beot;
        logic eof;
        logic rew;
    } err_latch_t;

    typedef struct packed {
        logic empty;
        logic wlk;
        logic rdy;
        logic rew;
    } live_bits_t;

    typedef struct packed {
        logic clear;
        logic load_a;
        logic go;
        logic read_b;
        logic skip_df;
        logic skip_err;
        logic skip_rdy;
        logic skip_any;
    } iot_cmd_t;

    function automatic logic fn_writes(tape_fn_e f);
        return (f == FN_WRITE) || (f == FN_GAP);
    endfunction

    function automatic logic stat_any_err(stat_word_t s);
        return s.wr_lock_err | s.crc_err | s.timing_err |
               s.end_mark | s.end_file | s.empty;
    endfunction

endpackage

// File: rtl/cas_iot_decode.sv
module cas_iot_decode
    import cas_pkg::*;
(
    input  logic     stb,
    input  logic [2:0] op,
    output iot_cmd_t cmd
);
    always_comb begin
        cmd = '0;
        if (stb) begin
            unique case (iot_op_e'(op))
                IOP_CLEAR:    cmd.clear    = 1'b1;
                IOP_SKIP_DF:  cmd.skip_df  = 1'b1;
                IOP_SKIP_ERR: cmd.skip_err = 1'b1;
                IOP_SKIP_RDY: cmd.skip_rdy = 1'b1;
                IOP_LOAD_A:   cmd.load_a   = 1'b1;
                IOP_SKIP_ANY: cmd.skip_any = 1'b1;
                IOP_GO:       cmd.go       = 1'b1;
                IOP_READ_B:   cmd.read_b   = 1'b1;
                default:      cmd          = '0;
            endcase
        end
    end
endmodule

// File: rtl/cas_unit_view.sv
module cas_unit_view
    import cas_pkg::*;
#(
    parameter int NDRV = 2,
    localparam int UW = (NDRV > 1) ? $clog2(NDRV) : 1
)(
    input  logic            enable,
    input  logic [UW-1:0]   sel,
    input  logic [NDRV-1:0] attached,
    input  logic [NDRV-1:0] wprot,
    input  logic [NDRV-1:0] busy,
    input  logic            rew_latch,
    output logic            any_busy,
    output live_bits_t      live
);
    logic          hit;
    logic [UW-1:0] hit_idx;
    logic [UW-1:0] idx;
    logic          have_unit;
    logic          u_att;
    logic          u_wp;
    logic          u_bsy;

    // scan from the top so the lowest busy drive is the one kept
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NDRV - 1; i >= 0; i--) begin
            if (busy[i]) begin
                hit     = 1'b1;
                hit_idx = UW'(i);
            end
        end
    end

    assign any_busy  = hit;
    assign have_unit = hit | enable;
    assign idx       = hit ? hit_idx : sel;
    assign u_att     = attached[idx];
    assign u_wp      = wprot[idx];
    assign u_bsy     = busy[idx];

    always_comb begin
        live = '0;
        if (have_unit) begin
            live.empty = ~u_att;
            live.rdy   = ~u_bsy;
            live.rew   = rew_latch & u_att & u_bsy;
            live.wlk   = ~u_att | u_wp | (rew_latch & u_att & u_bsy);
        end
    end
endmodule

// File: rtl/cas_status_latch.sv
module cas_status_latch
    import cas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_all,
    input  logic       clr_xfer,
    input  logic       set_wle,
    input  logic       set_rew,
    input  logic       ev_crc,
    input  logic       ev_eof,
    input  logic       ev_end,
    input  logic       df_set,
    input  logic       df_clr,
    output err_latch_t err,
    output logic       df
);
    logic late;

    assign late = df_set & df & ~df_clr;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            err <= '0;
            df  <= 1'b0;
        end else begin
            err.wle  <= (err.wle  & ~clr_xfer) | set_wle;
            err.crc  <= (err.crc  & ~clr_xfer) | ev_crc;
            err.tim  <= (err.tim  & ~clr_xfer) | late;
            err.beot <= (err.beot & ~clr_xfer) | ev_end;
            err.eof  <= (err.eof  & ~clr_xfer) | ev_eof;
            err.rew  <= (err.rew  & ~clr_xfer) | set_rew;
            df       <= (df & ~df_clr) | df_set;
        end
    end
endmodule

// File: rtl/cas_host_regs.sv
module cas_host_regs
    import cas_pkg::*;
#(
    parameter int NDRV = 2
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            iot_stb,
    input  logic [2:0]      iot_op,
    input  logic [11:0]     acc_in,
    input  logic [NDRV-1:0] drv_attached,
    input  logic [NDRV-1:0] drv_wprot,
    input  logic [NDRV-1:0] drv_busy,
    input  logic            eng_df_set,
    input  logic            eng_crc_err,
    input  logic            eng_eof,
    input  logic            eng_end_mark,
    output logic            res_valid,
    output logic [11:0]     res_acc,
    output logic            res_skip,
    output logic            irq,
    output logic            go_start,
    output logic            go_cont,
    output logic [2:0]      go_fn,
    output logic            go_unit,
    output logic [7:0]      go_wdata
);
    localparam int UW = (NDRV > 1) ? $clog2(NDRV) : 1;

    iot_cmd_t   cmd;
    cmd_reg_t   ra;
    err_latch_t err;
    live_bits_t live;
    stat_word_t sw_full;
    stat_word_t sw_vis;
    logic       df;
    logic       any_busy;
    logic [UW-1:0] sel;
    logic       err_any;
    logic       start_ok;
    logic       wle_hit;
    logic       start_go;
    logic       set_rew;

    cas_iot_decode u_dec (
        .stb (iot_stb),
        .op  (iot_op),
        .cmd (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            ra <= '0;
        end else if (cmd.load_a) begin
            ra.enable <= acc_in[7];
            ra.unit   <= acc_in[6];
            ra.fn     <= tape_fn_e'(acc_in[5:3]);
            ra.irq_en <= acc_in[0];
        end
    end

    assign sel = UW'(ra.unit);

    cas_unit_view #(.NDRV(NDRV)) u_view (
        .enable    (ra.enable),
        .sel       (sel),
        .attached  (drv_attached),
        .wprot     (drv_wprot),
        .busy      (drv_busy),
        .rew_latch (err.rew),
        .any_busy  (any_busy),
        .live      (live)
    );

    // go handling: start when idle, continue when a drive is moving
    assign start_ok = cmd.go & ~any_busy & ra.enable & drv_attached[sel];
    assign wle_hit  = start_ok & fn_writes(ra.fn) & drv_wprot[sel];
    assign start_go = start_ok & ~wle_hit;
    assign set_rew  = start_go & (ra.fn == FN_REWIND);

    cas_status_latch u_lat (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (cmd.clear),
        .clr_xfer (start_ok),
        .set_wle  (wle_hit),
        .set_rew  (set_rew),
        .ev_crc   (eng_crc_err),
        .ev_eof   (eng_eof),
        .ev_end   (eng_end_mark),
        .df_set   (eng_df_set),
        .df_clr   (cmd.go),
        .err      (err),
        .df       (df)
    );

    always_comb begin
        sw_full             = '0;
        sw_full.wr_lock_err = err.wle;
        sw_full.crc_err     = err.crc;
        sw_full.timing_err  = err.tim;
        sw_full.end_mark    = err.beot;
        sw_full.end_file    = err.eof;
        sw_full.empty       = live.empty;
        sw_full.rewinding   = live.rew;
        sw_full.wr_locked   = live.wlk;
        sw_full.ready       = live.rdy;
    end

    assign sw_vis  = ra.enable ? sw_full : '0;
    assign err_any = stat_any_err(sw_vis);
    assign irq     = ra.irq_en & (df | err_any | sw_vis.ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_acc   <= '0;
            res_skip  <= 1'b0;
            go_start  <= 1'b0;
            go_cont   <= 1'b0;
            go_fn     <= '0;
            go_unit   <= 1'b0;
            go_wdata  <= '0;
        end else begin
            res_valid <= iot_stb;
            res_skip  <= (cmd.skip_df  & df) |
                         (cmd.skip_err & err_any) |
                         (cmd.skip_rdy & sw_vis.ready & ~sw_vis.empty) |
                         (cmd.skip_any & (df | err_any | sw_vis.ready));
            if (cmd.load_a)
                res_acc <= {4'h0, ~acc_in[7:0]};
            else if (cmd.read_b)
                res_acc <= {4'h0, sw_vis[7:0]};
            else
                res_acc <= acc_in;
            go_start <= start_go;
            go_cont  <= cmd.go & any_busy;
            if (cmd.go) begin
                go_fn    <= ra.fn;
                go_unit  <= ra.unit;
                go_wdata <= acc_in[7:0];
            end
        end
    end
endmodule

// File: rtl/cas_host_regs_chk.sv
module cas_host_regs_chk
    import cas_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        iot_stb,
    input logic [2:0]  iot_op,
    input logic [11:0] acc_in,
    input logic        res_valid,
    input logic [11:0] res_acc,
    input logic        res_skip,
    input logic        irq,
    input logic        go_start,
    input logic        go_cont,
    input cmd_reg_t    ra
);
    p_res_follow_r11: assert property (@(posedge clk) disable iff (rst)
        iot_stb |=> res_valid);
    p_res_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !iot_stb |=> !res_valid);
    p_load_ret_r2: assert property (@(posedge clk) disable iff (rst)
        (iot_stb && iot_op == 3'd4) |=> (res_acc == {4'h0, ~$past(acc_in[7:0])}));
    p_readb_top_r3: assert property (@(posedge clk) disable iff (rst)
        (iot_stb && iot_op == 3'd7) |=> (res_acc[11:8] == 4'h0));
    p_no_skip_r5: assert property (@(posedge clk) disable iff (rst)
        (iot_stb && (iot_op == 3'd0 || iot_op == 3'd4 || iot_op == 3'd6 || iot_op == 3'd7))
        |=> !res_skip);
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !ra.irq_en |-> !irq);
    p_go_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (go_start || go_cont) |-> $past(iot_stb && iot_op == 3'd6));
    p_go_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(go_start && go_cont));
    p_clear_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (iot_stb && iot_op == 3'd0) |=> !irq);
endmodule

bind cas_host_regs cas_host_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iot_stb   (iot_stb),
    .iot_op    (iot_op),
    .acc_in    (acc_in),
    .res_valid (res_valid),
    .res_acc   (res_acc),
    .res_skip  (res_skip),
    .irq       (irq),
    .go_start  (go_start),
    .go_cont   (go_cont),
    .ra        (ra)
);

// File: tb/sim_cas_host_regs.sv
`timescale 1ns/1ps
module sim_cas_host_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iot_stb = 1'b0;
    logic [2:0]  iot_op = '0;
    logic [11:0] acc_in = '0;
    logic [1:0]  drv_attached = 2'b11;
    logic [1:0]  drv_wprot = 2'b00;
    logic [1:0]  drv_busy = 2'b00;
    logic        eng_df_set = 1'b0;
    logic        eng_crc_err = 1'b0;
    logic        eng_eof = 1'b0;
    logic        eng_end_mark = 1'b0;
    logic        res_valid;
    logic [11:0] res_acc;
    logic        res_skip;
    logic        irq;
    logic        go_start;
    logic        go_cont;
    logic [2:0]  go_fn;
    logic        go_unit;
    logic [7:0]  go_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] acc;
        logic        skip;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    cas_host_regs #(.NDRV(2)) u0 (
        .clk(clk), .rst(rst), .iot_stb(iot_stb), .iot_op(iot_op), .acc_in(acc_in),
        .drv_attached(drv_attached), .drv_wprot(drv_wprot), .drv_busy(drv_busy),
        .eng_df_set(eng_df_set), .eng_crc_err(eng_crc_err), .eng_eof(eng_eof),
        .eng_end_mark(eng_end_mark), .res_valid(res_valid), .res_acc(res_acc),
        .res_skip(res_skip), .irq(irq), .go_start(go_start), .go_cont(go_cont),
        .go_fn(go_fn), .go_unit(go_unit), .go_wdata(go_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: push the expected result, then issue one strobe
    task automatic iot(input logic [2:0] op, input logic [11:0] a,
                       input logic [11:0] e_acc, input logic e_skip, input string req);
        exp_t e;
        e.acc = e_acc; e.skip = e_skip; e.req = req;
        @(negedge clk);
        sb.push_back(e);
        iot_stb = 1'b1; iot_op = op; acc_in = a;
        @(negedge clk);
        iot_stb = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: eng_df_set = 1'b1;
            1: eng_crc_err = 1'b1;
            2: eng_eof = 1'b1;
            default: eng_end_mark = 1'b1;
        endcase
        @(negedge clk);
        eng_df_set = 1'b0; eng_crc_err = 1'b0; eng_eof = 1'b0; eng_end_mark = 1'b0;
    endtask

    // monitor: compare each result against the scoreboard head
    always @(posedge clk) begin
        #1;
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 unexpected result actual=%h expected=none", res_acc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.req, " acc"}, {20'h0, res_acc}, {20'h0, e.acc});
                chk({e.req, " skip"}, {31'h0, res_skip}, {31'h0, e.skip});
            end
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 valid", {31'h0, res_valid}, 0);
        chk("R1 go", {30'h0, go_start, go_cont}, 0);
        iot(3'd7, 12'o7777, 12'h000, 1'b0, "R1 R3 read disabled");

        // enable, drive 0, read function, no interrupts
        iot(3'd4, 12'o0200, 12'h07F, 1'b0, "R2 load");
        iot(3'd7, 12'h123, 12'h001, 1'b0, "R3 R4 idle ready");
        iot(3'd3, 12'h5A5, 12'h5A5, 1'b1, "R5 R11 skip ready");
        iot(3'd2, 12'h111, 12'h111, 1'b0, "R5 no error");
        iot(3'd1, 12'h222, 12'h222, 1'b0, "R5 no flag");
        iot(3'd5, 12'h333, 12'h333, 1'b1, "R5 any");

        // detach drive 0
        @(negedge clk); drv_attached = 2'b10;
        iot(3'd7, 12'h000, 12'h00B, 1'b0, "R4 detached");
        iot(3'd3, 12'h000, 12'h000, 1'b0, "R5 empty blocks ready skip");
        iot(3'd2, 12'h000, 12'h000, 1'b1, "R5 empty is error");

        // select drive 1 with interrupts
        iot(3'd4, 12'o0301, 12'h03E, 1'b0, "R2 load unit1");
        chk("R6 irq on ready", {31'h0, irq}, 1);
        @(negedge clk); drv_wprot = 2'b10;
        iot(3'd7, 12'h000, 12'h003, 1'b0, "R4 protected");

        // write on protected drive
        iot(3'd4, 12'o0321, 12'h02E, 1'b0, "R2 load write");
        iot(3'd6, 12'h0AB, 12'h0AB, 1'b0, "R11 go");
        chk("R7 no start when locked", {30'h0, go_start, go_cont}, 0);
        iot(3'd7, 12'h000, 12'h003, 1'b0, "R12 wle hidden");
        iot(3'd2, 12'h000, 12'h000, 1'b1, "R12 wle skip");

        // unprotect and start the write
        @(negedge clk); drv_wprot = 2'b00;
        iot(3'd6, 12'h0AB, 12'h0AB, 1'b0, "R7 go");
        chk("R7 start", {31'h0, go_start}, 1);
        chk("R7 fn", {29'h0, go_fn}, 2);
        chk("R7 unit", {31'h0, go_unit}, 1);
        chk("R7 data", {24'h0, go_wdata}, 32'hAB);
        iot(3'd2, 12'h000, 12'h000, 1'b0, "R7 wle cleared");
        @(negedge clk); drv_busy = 2'b10;
        iot(3'd7, 12'h000, 12'h000, 1'b0, "R4 busy not ready");
        chk("R6 irq off", {31'h0, irq}, 0);
        iot(3'd6, 12'h044, 12'h044, 1'b0, "R8 go busy");
        chk("R8 cont", {30'h0, go_start, go_cont}, 1);

        // data flag and late pulse
        pulse(0);
        chk("R6 irq on flag", {31'h0, irq}, 1);
        iot(3'd1, 12'h000, 12'h000, 1'b1, "R9 flag skip");
        pulse(0);
        iot(3'd7, 12'h000, 12'h040, 1'b0, "R9 timing");
        iot(3'd6, 12'h000, 12'h000, 1'b0, "R8 go clears flag");
        iot(3'd1, 12'h000, 12'h000, 1'b0, "R8 flag cleared");
        iot(3'd7, 12'h000, 12'h040, 1'b0, "R8 errors kept on continue");
        @(negedge clk); eng_crc_err = 1'b1; eng_eof = 1'b1;
        @(negedge clk); eng_crc_err = 1'b0; eng_eof = 1'b0;
        iot(3'd7, 12'h000, 12'h0D0, 1'b0, "R9 events");

        // rewind on drive 0
        @(negedge clk); drv_busy = 2'b00; drv_attached = 2'b11;
        iot(3'd4, 12'o0210, 12'h077, 1'b0, "R2 load rewind");
        iot(3'd7, 12'h000, 12'h0D1, 1'b0, "R3 errors with ready");
        iot(3'd6, 12'h000, 12'h000, 1'b0, "R7 go rewind");
        chk("R7 rewind start", {31'h0, go_start}, 1);
        iot(3'd7, 12'h000, 12'h001, 1'b0, "R7 errors cleared");
        @(negedge clk); drv_busy = 2'b01;
        iot(3'd7, 12'h000, 12'h006, 1'b0, "R4 R7 rewinding");
        @(negedge clk); drv_busy = 2'b00;
        pulse(3);
        iot(3'd7, 12'h000, 12'h021, 1'b0, "R9 end mark");

        // busy drive 1 overrides selected drive 0
        @(negedge clk); drv_attached = 2'b01; drv_busy = 2'b10;
        iot(3'd7, 12'h000, 12'h02A, 1'b0, "R4 busy unit priority");

        // disable
        @(negedge clk); drv_busy = 2'b00;
        iot(3'd4, 12'h000, 12'h0FF, 1'b0, "R2 load zero");
        iot(3'd7, 12'h000, 12'h000, 1'b0, "R3 hidden");
        chk("R6 irq disabled", {31'h0, irq}, 0);

        // clear with a same-cycle event
        iot(3'd4, 12'o0201, 12'h07E, 1'b0, "R2 reload");
        pulse(1);
        begin
            exp_t e;
            e.acc = 12'h0F0; e.skip = 1'b0; e.req = "R10 clear";
            @(negedge clk);
            sb.push_back(e);
            iot_stb = 1'b1; iot_op = 3'd0; acc_in = 12'h0F0; eng_crc_err = 1'b1;
            @(negedge clk);
            iot_stb = 1'b0; eng_crc_err = 1'b0;
        end
        chk("R10 irq", {31'h0, irq}, 0);
        iot(3'd7, 12'h000, 12'h000, 1'b0, "R10 command cleared");
        iot(3'd4, 12'o0200, 12'h07F, 1'b0, "R2 reload after clear");
        iot(3'd7, 12'h000, 12'h001, 1'b0, "R10 errors cleared");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11 missing results actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule